// File: doc/BRIEF.md
# Memory Fill Bridge

This block sits on an AXI4 path, between an upstream manager and a memory controller. After every reset it takes the downstream port for itself and writes a constant data word over a power-of-two byte region that starts at a base address. It does this with back-to-back 16-beat incrementing write bursts. While this fill runs, upstream traffic is held off. Write responses from the memory are consumed locally.

When every burst has been issued and every response has come back, the bridge becomes transparent. From then on, all five channels are wired straight through with no register stage. A completion flag also turns on at that point. It is a registered copy of a completion input, so several bridges, each guarding its own memory, can be chained into one combined "all memories ready" signal. When a bridge has no predecessor, its completion input is tied high.

Top module: `memfill_bridge`

## Requirements
- R1: After the synchronous active-low reset (`rst_n`) the bridge is in fill mode. In that mode `s_awready` and `s_arready` stay low even when the upstream valids and the downstream readies are high.
- R2: In fill mode `s_wready`, `s_bvalid` and `s_rvalid` stay low, `m_rready` is low, and `m_bready` is high.
- R3: Every generated write address carries `m_awlen`=15, `m_awsize`=log2(DATA_WIDTH/8), and `m_awburst`=2'b01 (INCR). `m_awid`, `m_awlock`, `m_awcache`, `m_awprot`, `m_awqos` and `m_awuser` are all zero.
- R4: There are exactly 2**REGION_LOG2 / (16·DATA_WIDTH/8) generated bursts. Burst k goes to BASE_ADDR + k·16·(DATA_WIDTH/8), issued in increasing order. A pending `m_awvalid` holds its address until it is accepted.
- R5: Every generated data beat carries INIT_WORD, all byte strobes set and `m_wuser`=0. `m_wlast` is high on the 16th beat of each burst and only there.
- R6: A data beat of burst k is offered only after the address handshake of burst k has completed.
- R7: Fill mode ends only after all bursts are issued and all responses are received. The upstream channels become transparent from the second rising edge after the last response handshake.
- R8: In pass-through mode every field of all five channels is copied between the ports in the same cycle. Each ready is copied back the opposite way, also in the same cycle.
- R9: `init_done_out` is low in fill mode. In pass-through mode it equals `init_done_in` as sampled at the previous rising edge.
- R10: A reset during pass-through mode returns the bridge to fill mode, drops `init_done_out`, and repeats the complete fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all channels |
| rst_n | input | 1 | Synchronous active-low reset |
| init_done_in | input | 1 | Completion from the previous bridge in a chain (tie high if unused) |
| init_done_out | output | 1 | Completion flag, registered |
| s_awid | input | ID_WIDTH | Upstream write address ID |
| s_awaddr | input | ADDR_WIDTH | Upstream write address |
| s_awlen | input | 8 | Upstream write burst length |
| s_awsize | input | 3 | Upstream write beat size |
| s_awburst | input | 2 | Upstream write burst type |
| s_awlock | input | 1 | Upstream write lock |
| s_awcache | input | 4 | Upstream write cache attributes |
| s_awprot | input | 3 | Upstream write protection |
| s_awqos | input | 4 | Upstream write QoS |
| s_awuser | input | USER_WIDTH | Upstream write address user bits |
| s_awvalid | input | 1 | Upstream write address valid |
| s_awready | output | 1 | Upstream write address ready |
| s_wdata | input | DATA_WIDTH | Upstream write data |
| s_wstrb | input | DATA_WIDTH/8 | Upstream byte strobes |
| s_wlast | input | 1 | Upstream last beat |
| s_wuser | input | USER_WIDTH | Upstream write data user bits |
| s_wvalid | input | 1 | Upstream write data valid |
| s_wready | output | 1 | Upstream write data ready |
| s_bid | output | ID_WIDTH | Upstream response ID |
| s_bresp | output | 2 | Upstream response code |
| s_bvalid | output | 1 | Upstream response valid |
| s_bready | input | 1 | Upstream response ready |
| s_arid | input | ID_WIDTH | Upstream read address ID |
| s_araddr | input | ADDR_WIDTH | Upstream read address |
| s_arlen | input | 8 | Upstream read burst length |
| s_arsize | input | 3 | Upstream read beat size |
| s_arburst | input | 2 | Upstream read burst type |
| s_arlock | input | 1 | Upstream read lock |
| s_arcache | input | 4 | Upstream read cache attributes |
| s_arprot | input | 3 | Upstream read protection |
| s_arqos | input | 4 | Upstream read QoS |
| s_arvalid | input | 1 | Upstream read address valid |
| s_arready | output | 1 | Upstream read address ready |
| s_rid | output | ID_WIDTH | Upstream read data ID |
| s_rdata | output | DATA_WIDTH | Upstream read data |
| s_rresp | output | 2 | Upstream read response |
| s_rlast | output | 1 | Upstream read last beat |
| s_rvalid | output | 1 | Upstream read data valid |
| s_rready | input | 1 | Upstream read data ready |
| m_awid | output | ID_WIDTH | Memory write address ID |
| m_awaddr | output | ADDR_WIDTH | Memory write address |
| m_awlen | output | 8 | Memory write burst length |
| m_awsize | output | 3 | Memory write beat size |
| m_awburst | output | 2 | Memory write burst type |
| m_awlock | output | 1 | Memory write lock |
| m_awcache | output | 4 | Memory write cache attributes |
| m_awprot | output | 3 | Memory write protection |
| m_awqos | output | 4 | Memory write QoS |
| m_awuser | output | USER_WIDTH | Memory write address user bits |
| m_awvalid | output | 1 | Memory write address valid |
| m_awready | input | 1 | Memory write address ready |
| m_wdata | output | DATA_WIDTH | Memory write data |
| m_wstrb | output | DATA_WIDTH/8 | Memory byte strobes |
| m_wlast | output | 1 | Memory last beat |
| m_wuser | output | USER_WIDTH | Memory write data user bits |
| m_wvalid | output | 1 | Memory write data valid |
| m_wready | input | 1 | Memory write data ready |
| m_bid | input | ID_WIDTH | Memory response ID |
| m_bresp | input | 2 | Memory response code |
| m_bvalid | input | 1 | Memory response valid |
| m_bready | output | 1 | Memory response ready |
| m_arid | output | ID_WIDTH | Memory read address ID |
| m_araddr | output | ADDR_WIDTH | Memory read address |
| m_arlen | output | 8 | Memory read burst length |
| m_arsize | output | 3 | Memory read beat size |
| m_arburst | output | 2 | Memory read burst type |
| m_arlock | output | 1 | Memory read lock |
| m_arcache | output | 4 | Memory read cache attributes |
| m_arprot | output | 3 | Memory read protection |
| m_arqos | output | 4 | Memory read QoS |
| m_arvalid | output | 1 | Memory read address valid |
| m_arready | input | 1 | Memory read address ready |
| m_rid | input | ID_WIDTH | Memory read data ID |
| m_rdata | input | DATA_WIDTH | Memory read data |
| m_rresp | input | 2 | Memory read response |
| m_rlast | input | 1 | Memory read last beat |
| m_rvalid | input | 1 | Memory read data valid |
| m_rready | output | 1 | Memory read data ready |

## Verification
The bench builds the bridge with a 32-bit data bus and REGION_LOG2 = 8, which makes the fill only four 64-byte bursts long. That keeps complete fills, and a second fill after a mid-operation reset, well inside the run. It also uses a non-zero, non-aligned-looking base of 0x2300 and a mixed-bit fill word, so an address step, base offset or data error shows up in the values. The ID and user widths are non-zero, so any leak of upstream ID or user bits into generated bursts is visible. The memory model stalls the address and data readies on different cycle patterns, which puts the data channel ahead of and behind the address channel.

// File: rtl/memfill_pkg.sv
`timescale 1ns/1ps
package memfill_pkg;
  // strobes from the fill sequencer to the channel muxing
  typedef struct packed {
    logic initMode;
    logic awValid;
    logic wValid;
    logic wLast;
  } fill_strobe_t;

  localparam int BEATS_PER_BURST = 16;
  localparam logic [1:0] BURST_INCR = 2'b01;
endpackage

// File: rtl/memfill_ctrl.sv
`timescale 1ns/1ps
module memfill_ctrl
  import memfill_pkg::*;
#(
  parameter int ADDR_WIDTH = 32,
  parameter int DATA_WIDTH = 32,
  parameter int REGION_LOG2 = 12,
  parameter logic [ADDR_WIDTH-1:0] BASE_ADDR = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  init_done_in,
  output logic                  init_done_out,
  input  logic                  m_awready,
  input  logic                  m_wready,
  input  logic                  m_bvalid,
  output fill_strobe_t          strobes,
  output logic [ADDR_WIDTH-1:0] genAwAddr
);
  localparam int BEAT_BYTES = DATA_WIDTH / 8;
  localparam int BEAT_W     = $clog2(BEATS_PER_BURST);
  localparam int BURST_LOG2 = $clog2(BEAT_BYTES) + BEAT_W;
  localparam int CNT_W      = REGION_LOG2 - BURST_LOG2 + 1;
  localparam logic [CNT_W-1:0] NUM_BURSTS = CNT_W'(1) << (CNT_W - 1);
  localparam logic [ADDR_WIDTH-1:0] ADDR_STEP = ADDR_WIDTH'(1) << BURST_LOG2;

  logic                  initMode;
  logic [CNT_W-1:0]      awCnt;     // bursts whose address was accepted
  logic [CNT_W-1:0]      wCnt;      // bursts whose data finished
  logic [CNT_W-1:0]      outstCnt;  // bursts awaiting a response
  logic [BEAT_W-1:0]     beatCnt;
  logic [ADDR_WIDTH-1:0] addrReg;
  logic                  doneQ;

  logic awValid, wValid, wLast, awHs, wHs, bHs, fillDone;

  always_comb begin
    awValid  = initMode && (awCnt != NUM_BURSTS);
    wValid   = initMode && (wCnt != awCnt);
    wLast    = &beatCnt;
    awHs     = awValid && m_awready;
    wHs      = wValid && m_wready;
    bHs      = initMode && m_bvalid && (outstCnt != '0);
    fillDone = (awCnt == NUM_BURSTS) && (wCnt == NUM_BURSTS) && (outstCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      initMode <= 1'b1;
      awCnt    <= '0;
      wCnt     <= '0;
      outstCnt <= '0;
      beatCnt  <= '0;
      addrReg  <= BASE_ADDR;
      doneQ    <= 1'b0;
    end else begin
      if (awHs) begin
        awCnt   <= awCnt + 1'b1;
        addrReg <= addrReg + ADDR_STEP;
      end
      if (wHs) begin
        beatCnt <= beatCnt + 1'b1;
        if (wLast) wCnt <= wCnt + 1'b1;
      end
      case ({awHs, bHs})
        2'b10:   outstCnt <= outstCnt + 1'b1;
        2'b01:   outstCnt <= outstCnt - 1'b1;
        default: ;
      endcase
      if (initMode && fillDone) initMode <= 1'b0;
      doneQ <= !initMode && init_done_in;
    end
  end

  assign strobes       = '{initMode: initMode, awValid: awValid, wValid: wValid, wLast: wLast};
  assign genAwAddr     = addrReg;
  assign init_done_out = doneQ;
endmodule

// File: rtl/memfill_datapath.sv
`timescale 1ns/1ps
module memfill_datapath
  import memfill_pkg::*;
#(
  parameter int ADDR_WIDTH = 32,
  parameter int DATA_WIDTH = 32,
  parameter int ID_WIDTH = 4,
  parameter int USER_WIDTH = 1,
  parameter logic [DATA_WIDTH-1:0] INIT_WORD = '0
) (
  input  fill_strobe_t            strobes,
  input  logic [ADDR_WIDTH-1:0]   genAwAddr,
  input  logic [ID_WIDTH-1:0]     s_awid,
  input  logic [ADDR_WIDTH-1:0]   s_awaddr,
  input  logic [7:0]              s_awlen,
  input  logic [2:0]              s_awsize,
  input  logic [1:0]              s_awburst,
  input  logic                    s_awlock,
  input  logic [3:0]              s_awcache,
  input  logic [2:0]              s_awprot,
  input  logic [3:0]              s_awqos,
  input  logic [USER_WIDTH-1:0]   s_awuser,
  input  logic                    s_awvalid,
  output logic                    s_awready,
  input  logic [DATA_WIDTH-1:0]   s_wdata,
  input  logic [DATA_WIDTH/8-1:0] s_wstrb,
  input  logic                    s_wlast,
  input  logic [USER_WIDTH-1:0]   s_wuser,
  input  logic                    s_wvalid,
  output logic                    s_wready,
  output logic [ID_WIDTH-1:0]     s_bid,
  output logic [1:0]              s_bresp,
  output logic                    s_bvalid,
  input  logic                    s_bready,
  input  logic [ID_WIDTH-1:0]     s_arid,
  input  logic [ADDR_WIDTH-1:0]   s_araddr,
  input  logic [7:0]              s_arlen,
  input  logic [2:0]              s_arsize,
  input  logic [1:0]              s_arburst,
  input  logic                    s_arlock,
  input  logic [3:0]              s_arcache,
  input  logic [2:0]              s_arprot,
  input  logic [3:0]              s_arqos,
  input  logic                    s_arvalid,
  output logic                    s_arready,
  output logic [ID_WIDTH-1:0]     s_rid,
  output logic [DATA_WIDTH-1:0]   s_rdata,
  output logic [1:0]              s_rresp,
  output logic                    s_rlast,
  output logic                    s_rvalid,
  input  logic                    s_rready,
  output logic [ID_WIDTH-1:0]     m_awid,
  output logic [ADDR_WIDTH-1:0]   m_awaddr,
  output logic [7:0]              m_awlen,
  output logic [2:0]              m_awsize,
  output logic [1:0]              m_awburst,
  output logic                    m_awlock,
  output logic [3:0]              m_awcache,
  output logic [2:0]              m_awprot,
  output logic [3:0]              m_awqos,
  output logic [USER_WIDTH-1:0]   m_awuser,
  output logic                    m_awvalid,
  input  logic                    m_awready,
  output logic [DATA_WIDTH-1:0]   m_wdata,
  output logic [DATA_WIDTH/8-1:0] m_wstrb,
  output logic                    m_wlast,
  output logic [USER_WIDTH-1:0]   m_wuser,
  output logic                    m_wvalid,
  input  logic                    m_wready,
  input  logic [ID_WIDTH-1:0]     m_bid,
  input  logic [1:0]              m_bresp,
  input  logic                    m_bvalid,
  output logic                    m_bready,
  output logic [ID_WIDTH-1:0]     m_arid,
  output logic [ADDR_WIDTH-1:0]   m_araddr,
  output logic [7:0]              m_arlen,
  output logic [2:0]              m_arsize,
  output logic [1:0]              m_arburst,
  output logic                    m_arlock,
  output logic [3:0]              m_arcache,
  output logic [2:0]              m_arprot,
  output logic [3:0]              m_arqos,
  output logic                    m_arvalid,
  input  logic                    m_arready,
  input  logic [ID_WIDTH-1:0]     m_rid,
  input  logic [DATA_WIDTH-1:0]   m_rdata,
  input  logic [1:0]              m_rresp,
  input  logic                    m_rlast,
  input  logic                    m_rvalid,
  output logic                    m_rready
);
  localparam logic [2:0] SIZE_CODE = 3'($clog2(DATA_WIDTH / 8));
  localparam logic [7:0] LEN_CODE  = 8'(BEATS_PER_BURST - 1);

  logic fill;
  assign fill = strobes.initMode;

  // write address: generated header in fill mode, upstream otherwise
  always_comb begin
    if (fill) begin
      m_awid    = '0;
      m_awaddr  = genAwAddr;
      m_awlen   = LEN_CODE;
      m_awsize  = SIZE_CODE;
      m_awburst = BURST_INCR;
      m_awlock  = 1'b0;
      m_awcache = '0;
      m_awprot  = '0;
      m_awqos   = '0;
      m_awuser  = '0;
      m_awvalid = strobes.awValid;
    end else begin
      m_awid    = s_awid;
      m_awaddr  = s_awaddr;
      m_awlen   = s_awlen;
      m_awsize  = s_awsize;
      m_awburst = s_awburst;
      m_awlock  = s_awlock;
      m_awcache = s_awcache;
      m_awprot  = s_awprot;
      m_awqos   = s_awqos;
      m_awuser  = s_awuser;
      m_awvalid = s_awvalid;
    end
  end
  assign s_awready = !fill && m_awready;

  // write data
  always_comb begin
    if (fill) begin
      m_wdata  = INIT_WORD;
      m_wstrb  = '1;
      m_wlast  = strobes.wLast;
      m_wuser  = '0;
      m_wvalid = strobes.wValid;
    end else begin
      m_wdata  = s_wdata;
      m_wstrb  = s_wstrb;
      m_wlast  = s_wlast;
      m_wuser  = s_wuser;
      m_wvalid = s_wvalid;
    end
  end
  assign s_wready = !fill && m_wready;

  // write response: swallowed while filling
  assign s_bid    = m_bid;
  assign s_bresp  = m_bresp;
  assign s_bvalid = !fill && m_bvalid;
  assign m_bready = fill || s_bready;

  // read address and data: fields always wired, handshakes gated
  assign m_arid    = s_arid;
  assign m_araddr  = s_araddr;
  assign m_arlen   = s_arlen;
  assign m_arsize  = s_arsize;
  assign m_arburst = s_arburst;
  assign m_arlock  = s_arlock;
  assign m_arcache = s_arcache;
  assign m_arprot  = s_arprot;
  assign m_arqos   = s_arqos;
  assign m_arvalid = !fill && s_arvalid;
  assign s_arready = !fill && m_arready;

  assign s_rid    = m_rid;
  assign s_rdata  = m_rdata;
  assign s_rresp  = m_rresp;
  assign s_rlast  = m_rlast;
  assign s_rvalid = !fill && m_rvalid;
  assign m_rready = !fill && s_rready;
endmodule

// File: rtl/memfill_bridge.sv
`timescale 1ns/1ps
module memfill_bridge
  import memfill_pkg::*;
#(
  parameter int ADDR_WIDTH = 32,
  parameter int DATA_WIDTH = 32,
  parameter int ID_WIDTH = 4,
  parameter int USER_WIDTH = 1,
  parameter int REGION_LOG2 = 12,
  parameter logic [ADDR_WIDTH-1:0] BASE_ADDR = '0,
  parameter logic [DATA_WIDTH-1:0] INIT_WORD = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    init_done_in,
  output logic                    init_done_out,
  input  logic [ID_WIDTH-1:0]     s_awid,
  input  logic [ADDR_WIDTH-1:0]   s_awaddr,
  input  logic [7:0]              s_awlen,
  input  logic [2:0]              s_awsize,
  input  logic [1:0]              s_awburst,
  input  logic                    s_awlock,
  input  logic [3:0]              s_awcache,
  input  logic [2:0]              s_awprot,
  input  logic [3:0]              s_awqos,
  input  logic [USER_WIDTH-1:0]   s_awuser,
  input  logic                    s_awvalid,
  output logic                    s_awready,
  input  logic [DATA_WIDTH-1:0]   s_wdata,
  input  logic [DATA_WIDTH/8-1:0] s_wstrb,
  input  logic                    s_wlast,
  input  logic [USER_WIDTH-1:0]   s_wuser,
  input  logic                    s_wvalid,
  output logic                    s_wready,
  output logic [ID_WIDTH-1:0]     s_bid,
  output logic [1:0]              s_bresp,
  output logic                    s_bvalid,
  input  logic                    s_bready,
  input  logic [ID_WIDTH-1:0]     s_arid,
  input  logic [ADDR_WIDTH-1:0]   s_araddr,
  input  logic [7:0]              s_arlen,
  input  logic [2:0]              s_arsize,
  input  logic [1:0]              s_arburst,
  input  logic                    s_arlock,
  input  logic [3:0]              s_arcache,
  input  logic [2:0]              s_arprot,
  input  logic [3:0]              s_arqos,
  input  logic                    s_arvalid,
  output logic                    s_arready,
  output logic [ID_WIDTH-1:0]     s_rid,
  output logic [DATA_WIDTH-1:0]   s_rdata,
  output logic [1:0]              s_rresp,
  output logic                    s_rlast,
  output logic                    s_rvalid,
  input  logic                    s_rready,
  output logic [ID_WIDTH-1:0]     m_awid,
  output logic [ADDR_WIDTH-1:0]   m_awaddr,
  output logic [7:0]              m_awlen,
  output logic [2:0]              m_awsize,
  output logic [1:0]              m_awburst,
  output logic                    m_awlock,
  output logic [3:0]              m_awcache,
  output logic [2:0]              m_awprot,
  output logic [3:0]              m_awqos,
  output logic [USER_WIDTH-1:0]   m_awuser,
  output logic                    m_awvalid,
  input  logic                    m_awready,
  output logic [DATA_WIDTH-1:0]   m_wdata,
  output logic [DATA_WIDTH/8-1:0] m_wstrb,
  output logic                    m_wlast,
  output logic [USER_WIDTH-1:0]   m_wuser,
  output logic                    m_wvalid,
  input  logic                    m_wready,
  input  logic [ID_WIDTH-1:0]     m_bid,
  input  logic [1:0]              m_bresp,
  input  logic                    m_bvalid,
  output logic                    m_bready,
  output logic [ID_WIDTH-1:0]     m_arid,
  output logic [ADDR_WIDTH-1:0]   m_araddr,
  output logic [7:0]              m_arlen,
  output logic [2:0]              m_arsize,
  output logic [1:0]              m_arburst,
  output logic                    m_arlock,
  output logic [3:0]              m_arcache,
  output logic [2:0]              m_arprot,
  output logic [3:0]              m_arqos,
  output logic                    m_arvalid,
  input  logic                    m_arready,
  input  logic [ID_WIDTH-1:0]     m_rid,
  input  logic [DATA_WIDTH-1:0]   m_rdata,
  input  logic [1:0]              m_rresp,
  input  logic                    m_rlast,
  input  logic                    m_rvalid,
  output logic                    m_rready
);
  fill_strobe_t          strobes;
  logic [ADDR_WIDTH-1:0] genAwAddr;
  logic                  initMode;

  assign initMode = strobes.initMode;

  memfill_ctrl #(
    .ADDR_WIDTH (ADDR_WIDTH),
    .DATA_WIDTH (DATA_WIDTH),
    .REGION_LOG2(REGION_LOG2),
    .BASE_ADDR  (BASE_ADDR)
  ) u_ctrl (.*);

  memfill_datapath #(
    .ADDR_WIDTH(ADDR_WIDTH),
    .DATA_WIDTH(DATA_WIDTH),
    .ID_WIDTH  (ID_WIDTH),
    .USER_WIDTH(USER_WIDTH),
    .INIT_WORD (INIT_WORD)
  ) u_dp (.*);
endmodule

// File: rtl/memfill_bridge_chk.sv
`timescale 1ns/1ps
module memfill_bridge_chk #(
  parameter int ADDR_WIDTH = 32,
  parameter int DATA_WIDTH = 32,
  parameter logic [DATA_WIDTH-1:0] INIT_WORD = '0
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    initMode,
  input logic                    s_awready,
  input logic                    s_arready,
  input logic                    s_bvalid,
  input logic                    m_bready,
  input logic                    m_awvalid,
  input logic                    m_awready,
  input logic [ADDR_WIDTH-1:0]   m_awaddr,
  input logic [7:0]              m_awlen,
  input logic [1:0]              m_awburst,
  input logic                    m_wvalid,
  input logic [DATA_WIDTH-1:0]   m_wdata,
  input logic [DATA_WIDTH/8-1:0] m_wstrb,
  input logic                    init_done_in,
  input logic                    init_done_out
);
  AST_FILL_BLOCKS_CMDS: assert property (@(posedge clk) disable iff (!rst_n)
    initMode |-> (!s_awready && !s_arready)); // R1

  AST_FILL_EATS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    initMode |-> (!s_bvalid && m_bready)); // R2

  AST_GEN_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
    (initMode && m_awvalid) |-> (m_awlen == 8'd15 && m_awburst == 2'b01)); // R3

  AST_AW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (initMode && m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr))); // R4

  AST_GEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (initMode && m_wvalid) |-> (m_wdata == INIT_WORD && (&m_wstrb))); // R5

  AST_DONE_LOW_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    initMode |-> !init_done_out); // R9

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!initMode && $past(!initMode)) |-> (init_done_out == $past(init_done_in))); // R9
endmodule

bind memfill_bridge memfill_bridge_chk #(
  .ADDR_WIDTH(ADDR_WIDTH),
  .DATA_WIDTH(DATA_WIDTH),
  .INIT_WORD (INIT_WORD)
) u_chk (.*);

// File: tb/memfill_bridge_tb.sv
`timescale 1ns/1ps
module memfill_bridge_tb;
  localparam int AW = 32, DW = 32, IW = 4, UW = 2, RL = 8;
  localparam logic [AW-1:0] BASE = 32'h0000_2300;
  localparam logic [DW-1:0] FILL = 32'hA5C3_0F17;
  localparam int NB = (1 << RL) / (16 * (DW / 8));
  localparam int STEP = 16 * (DW / 8);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, init_done_in, init_done_out;
  logic [IW-1:0] s_awid, m_awid, s_bid, m_bid, s_arid, m_arid, s_rid, m_rid;
  logic [AW-1:0] s_awaddr, m_awaddr, s_araddr, m_araddr;
  logic [7:0] s_awlen, m_awlen, s_arlen, m_arlen;
  logic [2:0] s_awsize, m_awsize, s_arsize, m_arsize, s_awprot, m_awprot, s_arprot, m_arprot;
  logic [1:0] s_awburst, m_awburst, s_arburst, m_arburst, s_bresp, m_bresp, s_rresp, m_rresp;
  logic s_awlock, m_awlock, s_arlock, m_arlock;
  logic [3:0] s_awcache, m_awcache, s_arcache, m_arcache, s_awqos, m_awqos, s_arqos, m_arqos;
  logic [UW-1:0] s_awuser, m_awuser, s_wuser, m_wuser;
  logic s_awvalid, s_awready, m_awvalid, m_awready;
  logic [DW-1:0] s_wdata, m_wdata, s_rdata, m_rdata;
  logic [DW/8-1:0] s_wstrb, m_wstrb;
  logic s_wlast, m_wlast, s_wvalid, s_wready, m_wvalid, m_wready;
  logic s_bvalid, s_bready, m_bvalid, m_bready;
  logic s_arvalid, s_arready, m_arvalid, m_arready;
  logic s_rlast, m_rlast, s_rvalid, s_rready, m_rvalid, m_rready;

  // memory-side drive: model while filling, bench tasks otherwise
  logic mdlOn = 1'b1;
  logic mdlAwready = 0, mdlWready = 0, mdlBvalid = 0;
  logic [IW-1:0] mdlBid = '0;
  logic tbAwready = 0, tbWready = 0, tbBvalid = 0;
  logic [IW-1:0] tbBid = '0;
  logic [1:0] tbBresp = '0;
  assign m_awready = mdlOn ? mdlAwready : tbAwready;
  assign m_wready  = mdlOn ? mdlWready  : tbWready;
  assign m_bvalid  = mdlOn ? mdlBvalid  : tbBvalid;
  assign m_bid     = mdlOn ? mdlBid     : tbBid;
  assign m_bresp   = mdlOn ? 2'b10      : tbBresp;

  memfill_bridge #(
    .ADDR_WIDTH(AW), .DATA_WIDTH(DW), .ID_WIDTH(IW), .USER_WIDTH(UW),
    .REGION_LOG2(RL), .BASE_ADDR(BASE), .INIT_WORD(FILL)
  ) u_dut (.*);

  int nChecks = 0, nErr = 0;
  int mAw = 0, mWBeat = 0, mWBursts = 0, mB = 0, cyc = 0;
  logic [AW-1:0] expAddrQ[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  endtask

  // scoreboard driver: expected burst addresses of one complete fill
  task automatic pushFill();
    for (int k = 0; k < NB; k++) expAddrQ.push_back(BASE + AW'(k * STEP));
  endtask

  // memory model and monitor
  initial begin : mem_model
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) begin
        mAw = 0; mWBeat = 0; mWBursts = 0; mB = 0;
      end
      mdlAwready = (cyc % 3) != 0;
      mdlWready  = (cyc % 4) != 1;
      mdlBvalid  = mWBursts > mB;
      mdlBid     = IW'(cyc);
      #1;
      if (mdlOn && rst_n) begin
        if (mB < NB) begin
          check(!s_awready && !s_arready, "R1", "upstream cmd ready during fill",
                {s_awready, s_arready}, 0);
          check(!s_wready && !s_rvalid && !s_bvalid && m_bready && !m_rready, "R2",
                "upstream gating during fill",
                {s_wready, s_rvalid, s_bvalid, m_bready, m_rready}, 5'b00010);
        end
        if (m_wvalid && m_wready) begin
          check(mWBursts < mAw, "R6", "data beat ahead of address", mWBursts, mAw);
          check(m_wdata == FILL && (&m_wstrb) && m_wuser == '0, "R5", "beat content",
                {m_wstrb, m_wdata}, {4'hF, FILL});
          check(m_wlast == (mWBeat == 15), "R5", "wlast position", m_wlast, mWBeat == 15);
          if (mWBeat == 15) begin mWBeat = 0; mWBursts++; end
          else mWBeat++;
        end
        if (m_awvalid && m_awready) begin
          if (expAddrQ.size() == 0) check(0, "R4", "unexpected extra burst", m_awaddr, 0);
          else begin
            logic [AW-1:0] ea;
            ea = expAddrQ.pop_front();
            check(m_awaddr == ea, "R4", "burst address", m_awaddr, ea);
          end
          check(m_awlen == 8'd15 && m_awsize == 3'd2 && m_awburst == 2'b01, "R3",
                "len/size/burst", {m_awlen, m_awsize, m_awburst}, {8'd15, 3'd2, 2'b01});
          check(m_awid == 0 && !m_awlock && m_awcache == 0 && m_awprot == 0 &&
                m_awqos == 0 && m_awuser == 0, "R3", "zero attributes",
                {m_awid, m_awlock, m_awcache, m_awprot, m_awqos, m_awuser}, 0);
          mAw++;
        end
        if (m_bvalid && m_bready) mB++;
      end
    end
  end

  // zero-latency pass-through of all five channels
  task automatic passCheck(input bit v);
    @(negedge clk);
    s_awid = IW'($urandom); s_awaddr = $urandom; s_awlen = 8'($urandom); s_awsize = 3'($urandom);
    s_awburst = 2'($urandom); s_awlock = 1'($urandom); s_awcache = 4'($urandom);
    s_awprot = 3'($urandom); s_awqos = 4'($urandom); s_awuser = UW'($urandom); s_awvalid = v;
    s_wdata = $urandom; s_wstrb = 4'($urandom); s_wlast = 1'($urandom); s_wuser = UW'($urandom);
    s_wvalid = v; s_bready = !v;
    s_arid = IW'($urandom); s_araddr = $urandom; s_arlen = 8'($urandom); s_arsize = 3'($urandom);
    s_arburst = 2'($urandom); s_arlock = 1'($urandom); s_arcache = 4'($urandom);
    s_arprot = 3'($urandom); s_arqos = 4'($urandom); s_arvalid = v; s_rready = !v;
    tbAwready = !v; tbWready = !v; tbBvalid = v; tbBid = IW'($urandom); tbBresp = 2'($urandom);
    m_arready = !v; m_rvalid = v; m_rid = IW'($urandom); m_rdata = $urandom;
    m_rresp = 2'($urandom); m_rlast = 1'($urandom);
    #1;
    check({m_awid, m_awaddr, m_awlen, m_awsize, m_awburst, m_awlock, m_awcache, m_awprot,
           m_awqos, m_awuser, m_awvalid} ==
          {s_awid, s_awaddr, s_awlen, s_awsize, s_awburst, s_awlock, s_awcache, s_awprot,
           s_awqos, s_awuser, s_awvalid} && s_awready == m_awready, "R8", "AW pass",
          {m_awaddr, m_awvalid, s_awready}, {s_awaddr, s_awvalid, m_awready});
    check({m_wdata, m_wstrb, m_wlast, m_wuser, m_wvalid} ==
          {s_wdata, s_wstrb, s_wlast, s_wuser, s_wvalid} && s_wready == m_wready, "R8",
          "W pass", {m_wdata, m_wvalid, s_wready}, {s_wdata, s_wvalid, m_wready});
    check({s_bid, s_bresp, s_bvalid} == {m_bid, m_bresp, m_bvalid} && m_bready == s_bready,
          "R8", "B pass", {s_bid, s_bresp, s_bvalid, m_bready}, {m_bid, m_bresp, m_bvalid, s_bready});
    check({m_arid, m_araddr, m_arlen, m_arsize, m_arburst, m_arlock, m_arcache, m_arprot,
           m_arqos, m_arvalid} ==
          {s_arid, s_araddr, s_arlen, s_arsize, s_arburst, s_arlock, s_arcache, s_arprot,
           s_arqos, s_arvalid} && s_arready == m_arready, "R8", "AR pass",
          {m_araddr, m_arvalid, s_arready}, {s_araddr, s_arvalid, m_arready});
    check({s_rid, s_rdata, s_rresp, s_rlast, s_rvalid} ==
          {m_rid, m_rdata, m_rresp, m_rlast, m_rvalid} && m_rready == s_rready, "R8",
          "R pass", {s_rdata, s_rvalid, m_rready}, {m_rdata, m_rvalid, s_rready});
  endtask

  // after the last response handshake: one more fill cycle, then pass-through
  task automatic checkHandover(input string req);
    @(negedge clk);
    mdlOn = 1'b0; tbAwready = 1'b1; tbWready = 1'b1; tbBvalid = 1'b0;
    #1;
    check(!s_awready, req, "ready one cycle after last response", s_awready, 0);
    @(negedge clk); #1;
    check(s_awready, "R7", "ready two cycles after last response", s_awready, 1);
    check(!init_done_out, "R9", "completion is registered", init_done_out, 0);
    @(negedge clk); #1;
    check(init_done_out, req, "completion after fill", init_done_out, 1);
    check(expAddrQ.size() == 0 && mAw == NB && mWBursts == NB, "R4", "burst count",
          mAw, NB);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finishRun();
  end

  initial begin : main
    rst_n = 1'b0; init_done_in = 1'b1;
    s_awid = '1; s_awaddr = 32'hDEAD_0000; s_awlen = 8'd3; s_awsize = 3'd1; s_awburst = 2'b10;
    s_awlock = 1'b1; s_awcache = 4'hF; s_awprot = 3'h7; s_awqos = 4'hF; s_awuser = '1;
    s_awvalid = 1'b1;
    s_wdata = 32'h1234_5678; s_wstrb = 4'h3; s_wlast = 1'b0; s_wuser = '1; s_wvalid = 1'b1;
    s_bready = 1'b1;
    s_arid = '1; s_araddr = 32'hBEEF_0000; s_arlen = 8'd1; s_arsize = 3'd2; s_arburst = 2'b01;
    s_arlock = 1'b0; s_arcache = 4'h3; s_arprot = 3'h1; s_arqos = 4'h2; s_arvalid = 1'b1;
    s_rready = 1'b1;
    m_arready = 1'b1; m_rvalid = 1'b1; m_rid = '0; m_rdata = '0; m_rresp = '0; m_rlast = 1'b1;
    pushFill();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!init_done_out && !s_awready && !s_arready, "R1", "state after reset",
          {init_done_out, s_awready, s_arready}, 0);
    wait (mB == NB);
    checkHandover("R7");

    passCheck(1'b1);
    passCheck(1'b0);
    passCheck(1'b1);

    @(negedge clk);
    init_done_in = 1'b0;
    #1;
    check(init_done_out, "R9", "completion holds until next edge", init_done_out, 1);
    @(negedge clk); #1;
    check(!init_done_out, "R9", "completion follows low input", init_done_out, 0);
    init_done_in = 1'b1;
    @(negedge clk); #1;
    check(init_done_out, "R9", "completion follows high input", init_done_out, 1);

    // reset in pass-through mode repeats the fill
    s_awvalid = 1'b1; s_arvalid = 1'b1; s_wvalid = 1'b1; s_bready = 1'b1; s_rready = 1'b1;
    m_rvalid = 1'b1; m_arready = 1'b1;
    @(negedge clk);
    rst_n = 1'b0; mdlOn = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    pushFill();
    #1;
    check(!init_done_out && !s_awready, "R10", "fill mode again after reset",
          {init_done_out, s_awready}, 0);
    wait (mB == NB);
    checkHandover("R10");

    finishRun();
  end
endmodule